// File: doc/BRIEF.md
# Dual-Channel Sampler Serial Frame Sequencer

This block is the digital sequencer of a front end that samples two converters, A and B, at the same instant. The conversion itself is stood in for by four 12-bit sample words on input ports, one per input (A0, A1, B0, B1). A rising edge on the start strobe begins a conversion. The sequencer then picks an input pair, captures the two matching words and raises busy. It then shifts 16-bit frames out of two serial pins, changing data on the rising clock edge.

The mode bits pick how the pair is chosen and how results leave the block. Mode bit 0 selects either the address input or automatic alternation between the pairs. Mode bit 1 selects either two pins in parallel or a single pin that carries both frames back to back. Each serial pin has an output-enable. Chip select, active low, gates both enables, and in single-pin mode pin B stays disabled.

Top module: `pair_frame_seq`

## Requirements
- R1: After reset, busy, both serial data outputs and the automatic pair state are all zero.
- R2: A start is accepted on a clock edge where the strobe is high and was low on the previous edge, if the block is idle or is driving the final bit of its frame. Busy is high from that edge, and the first frame bit is driven from that same edge.
- R3: A frame is 16 bits, one per clock. In order, the bits are: the pair tag (1 = pair 1), the converter tag (0 = A, 1 = B), the 12-bit two's complement word MSB first, and then two zeros. In two-pin mode (mode bit 1 = 0), the A frame is on pin A and the B frame is on pin B in the same cycles.
- R4: With mode bit 0 low, the address input sampled at the accepting edge selects the pair: 1 selects A1/B1 and 0 selects A0/B0.
- R5: With mode bit 0 high, the address input is ignored and the pairs alternate on each accepted start. The sequence begins at pair 0 after reset and after any conversion that was accepted with mode bit 0 low.
- R6: With mode bit 1 high at the accepting edge, pin A sends the A frame followed at once by the B frame (32 clocks). For that conversion, pin B data is 0 and its enable is low.
- R7: A start edge that arrives while busy, other than in the final bit cycle, is ignored. In single-pin mode, this drops every second start when starts come each 16 clocks.
- R8: Busy stays high for exactly 16 clocks (two-pin mode) or 32 clocks (single-pin mode). It falls on the edge after the last bit, unless a new start is accepted on that edge, in which case the frames follow each other without a gap.
- R9: With chip select high, both output enables are low. With it low, the pin A enable is high and the pin B enable is high unless the most recent accepted conversion used single-pin mode.
- R10: The sample words are captured at the accepting edge. Later changes to the sample inputs do not alter the frame in progress.
- R11: While idle, both serial data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one frame bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | Conversion-start strobe, edge-detected |
| cs_n_i | input | 1 | Chip select, active low, gates the output enables |
| mode_i | input | 2 | Bit 0: automatic pair alternation; bit 1: single-pin output |
| addr_i | input | 1 | Pair address used when mode bit 0 is low |
| smp_a0_i | input | 12 | Sample word for converter A, pair 0 |
| smp_a1_i | input | 12 | Sample word for converter A, pair 1 |
| smp_b0_i | input | 12 | Sample word for converter B, pair 0 |
| smp_b1_i | input | 12 | Sample word for converter B, pair 1 |
| busy_o | output | 1 | High while a conversion's frames are being sent |
| ser_a_o | output | 1 | Serial data, pin A |
| ser_a_oe_o | output | 1 | Output enable for pin A |
| ser_b_o | output | 1 | Serial data, pin B |
| ser_b_oe_o | output | 1 | Output enable for pin B |

## Verification
Two functions can fall in the same cycle: the end of one frame and the acceptance of the next start. Starts spaced exactly 16 clocks apart provoke this. In two-pin mode the new start must be taken in the final bit cycle and the next pair tag must follow directly, with busy never dropping. In single-pin mode the same spacing lands a start inside the frame, so that start must be dropped. A behavioural queue model, compared every cycle on busy, both data pins and both enables, judges both outcomes.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  // Bit idx of one frame: pair tag, converter tag, word MSB first, then zeros.
  function automatic logic frame_bit(input logic pair, input logic conv,
                                     input logic [31:0] w, input int dw,
                                     input int idx);
    logic [4:0] pos;
    if (idx == 0) return pair;
    if (idx == 1) return conv;
    if (idx >= 2 && idx < dw + 2) begin
      pos = 5'(dw + 1 - idx);
      return w[pos];
    end
    return 1'b0;
  endfunction

endpackage

// File: rtl/pfs_start_ctl.sv
module pfs_start_ctl #(
  parameter int FL = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          single_i,
  output logic          accept_o,
  output logic          drive_o,
  output logic          busy_o,
  output logic          single_q_o,
  output logic          single_nxt_o,
  output logic [CW-1:0] idx_o
);
  localparam logic [CW-1:0] END_ONE = CW'(FL - 1);
  localparam logic [CW-1:0] END_TWO = CW'(2 * FL - 1);

  logic          start_q, busy_q, single_q;
  logic [CW-1:0] cnt_q;
  logic          rise, last;

  assign rise     = start_i & ~start_q;
  assign last     = busy_q && (cnt_q == (single_q ? END_TWO : END_ONE));
  assign accept_o = rise && (!busy_q || last);
  assign drive_o  = accept_o || (busy_q && !last);
  assign idx_o    = accept_o ? '0 : cnt_q + 1'b1;
  assign busy_o   = busy_q;
  assign single_q_o   = single_q;
  assign single_nxt_o = accept_o ? single_i : single_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      busy_q   <= 1'b0;
      single_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      start_q <= start_i;
      if (accept_o) begin
        busy_q   <= 1'b1;
        cnt_q    <= '0;
        single_q <= single_i;
      end else if (last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: an accepted start raises busy and restarts the bit count
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (busy_q && cnt_q == '0));

  // R7: an edge inside a frame leaves the frame running
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  // R8: busy only falls after the final bit of the frame length in use
  p_frame_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == ($past(single_q) ? END_TWO : END_ONE)));

endmodule

// File: rtl/pfs_pair_sel.sv
module pfs_pair_sel #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          auto_i,
  input  logic          addr_i,
  input  logic [DW-1:0] a0_i,
  input  logic [DW-1:0] a1_i,
  input  logic [DW-1:0] b0_i,
  input  logic [DW-1:0] b1_i,
  output logic          pair_nxt_o,
  output logic          pair_q_o,
  output logic [DW-1:0] word_a_o,
  output logic [DW-1:0] word_b_o
);
  logic          alt_q, pair_q;
  logic [DW-1:0] wa_q, wb_q;
  logic          pair_now;

  assign pair_now   = auto_i ? alt_q : addr_i;
  assign pair_nxt_o = accept_i ? pair_now : pair_q;
  assign pair_q_o   = pair_q;
  assign word_a_o   = wa_q;
  assign word_b_o   = wb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q  <= 1'b0;
      pair_q <= 1'b0;
      wa_q   <= '0;
      wb_q   <= '0;
    end else if (accept_i) begin
      pair_q <= pair_now;
      wa_q   <= pair_now ? a1_i : a0_i;
      wb_q   <= pair_now ? b1_i : b0_i;
      alt_q  <= auto_i ? ~alt_q : 1'b0;
    end
  end

  // R10: captured words and pair hold between accepted starts
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> ($stable(wa_q) && $stable(wb_q) && $stable(pair_q)));

endmodule

// File: rtl/pfs_shifter.sv
module pfs_shifter #(
  parameter int DW = 12,
  parameter int FL = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drive_i,
  input  logic [CW-1:0] idx_i,
  input  logic          single_i,
  input  logic          pair_i,
  input  logic [DW-1:0] word_a_i,
  input  logic [DW-1:0] word_b_i,
  output logic          sda_o,
  output logic          sdb_o
);
  import pfs_pkg::*;

  logic sda_q, sdb_q, sda_d, sdb_d;
  int   idx;

  always_comb begin
    idx   = int'(idx_i);
    sda_d = 1'b0;
    sdb_d = 1'b0;
    if (drive_i) begin
      if (single_i && idx >= FL)
        sda_d = frame_bit(pair_i, 1'b1, 32'(word_b_i), DW, idx - FL);
      else
        sda_d = frame_bit(pair_i, 1'b0, 32'(word_a_i), DW, idx);
      if (!single_i)
        sdb_d = frame_bit(pair_i, 1'b1, 32'(word_b_i), DW, idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b0;
      sdb_q <= 1'b0;
    end else begin
      sda_q <= sda_d;
      sdb_q <= sdb_d;
    end
  end

  assign sda_o = sda_q;
  assign sdb_o = sdb_q;

  // R11: nothing driven means both pins read zero
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_i |=> (!sda_q && !sdb_q));

  // R6: pin B carries no data in single-pin mode
  p_single_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_i && single_i) |=> !sdb_q);

endmodule

// File: rtl/pair_frame_seq.sv
module pair_frame_seq #(
  parameter int DW = 12,
  parameter int FL = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_start_i,
  input  logic          cs_n_i,
  input  logic [1:0]    mode_i,
  input  logic          addr_i,
  input  logic [DW-1:0] smp_a0_i,
  input  logic [DW-1:0] smp_a1_i,
  input  logic [DW-1:0] smp_b0_i,
  input  logic [DW-1:0] smp_b1_i,
  output logic          busy_o,
  output logic          ser_a_o,
  output logic          ser_a_oe_o,
  output logic          ser_b_o,
  output logic          ser_b_oe_o
);
  localparam int CW = $clog2(2 * FL);

  logic          accept, drive, single_q, single_nxt, pair_nxt, pair_q;
  logic [CW-1:0] idx;
  logic [DW-1:0] word_a, word_b;

  pfs_start_ctl #(.FL(FL), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start_i(conv_start_i), .single_i(mode_i[1]),
    .accept_o(accept), .drive_o(drive), .busy_o(busy_o),
    .single_q_o(single_q), .single_nxt_o(single_nxt), .idx_o(idx)
  );

  pfs_pair_sel #(.DW(DW)) u_sel (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .auto_i(mode_i[0]),
    .addr_i(addr_i), .a0_i(smp_a0_i), .a1_i(smp_a1_i), .b0_i(smp_b0_i),
    .b1_i(smp_b1_i), .pair_nxt_o(pair_nxt), .pair_q_o(pair_q),
    .word_a_o(word_a), .word_b_o(word_b)
  );

  pfs_shifter #(.DW(DW), .FL(FL), .CW(CW)) u_shf (
    .clk(clk), .rst_n(rst_n), .drive_i(drive), .idx_i(idx),
    .single_i(single_nxt), .pair_i(pair_nxt), .word_a_i(word_a),
    .word_b_i(word_b), .sda_o(ser_a_o), .sdb_o(ser_b_o)
  );

  assign ser_a_oe_o = ~cs_n_i;
  assign ser_b_oe_o = ~cs_n_i & ~single_q;

  // R3: the first bit of every accepted frame is the pair just chosen
  p_tag_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ser_a_o == pair_q));

endmodule

// File: tb/pair_frame_seq_test.sv
module pair_frame_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cs_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        addr = 1'b0;
  logic [11:0] s_a0 = 12'h000, s_a1 = 12'h000, s_b0 = 12'h000, s_b1 = 12'h000;
  logic        busy, sda, sda_oe, sdb, sdb_oe;

  int    tests = 0;
  int    fails = 0;
  string cur_req = "R2";

  always #5 clk = ~clk;

  pair_frame_seq uut (
    .clk(clk), .rst_n(rst_n), .conv_start_i(start), .cs_n_i(cs_n),
    .mode_i(mode), .addr_i(addr), .smp_a0_i(s_a0), .smp_a1_i(s_a1),
    .smp_b0_i(s_b0), .smp_b1_i(s_b1), .busy_o(busy), .ser_a_o(sda),
    .ser_a_oe_o(sda_oe), .ser_b_o(sdb), .ser_b_oe_o(sdb_oe)
  );

  // Reference model: bit queues filled per accepted start
  bit qa[$];
  bit qb[$];
  bit m_busy = 0, m_single = 0, m_alt = 0, m_da = 0, m_db = 0, m_prev = 0;

  function automatic void push_frame(ref bit q[$], input bit pair,
                                     input bit conv, input logic [11:0] w);
    q.push_back(pair);
    q.push_back(conv);
    for (int i = 11; i >= 0; i--) q.push_back(w[i]);
    q.push_back(1'b0);
    q.push_back(1'b0);
  endfunction

  always @(posedge clk) begin
    bit rise, pair;
    logic [11:0] wa, wb;
    if (!rst_n) begin
      qa.delete(); qb.delete();
      m_busy = 0; m_single = 0; m_alt = 0; m_da = 0; m_db = 0; m_prev = 0;
    end else begin
      rise = start && !m_prev;
      m_prev = start;
      if (rise && qa.size() == 0) begin
        pair = mode[0] ? m_alt : addr;
        m_alt = mode[0] ? !m_alt : 1'b0;
        m_single = mode[1];
        wa = pair ? s_a1 : s_a0;
        wb = pair ? s_b1 : s_b0;
        if (m_single) begin
          push_frame(qa, pair, 1'b0, wa);
          push_frame(qa, pair, 1'b1, wb);
          repeat (32) qb.push_back(1'b0);
        end else begin
          push_frame(qa, pair, 1'b0, wa);
          push_frame(qb, pair, 1'b1, wb);
        end
        m_busy = 1;
        m_da = qa.pop_front();
        m_db = qb.pop_front();
      end else if (m_busy) begin
        if (qa.size() == 0) begin
          m_busy = 0; m_da = 0; m_db = 0;
        end else begin
          m_da = qa.pop_front();
          m_db = qb.pop_front();
        end
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      chk("R8", "busy", busy, m_busy);
      chk(cur_req, "pin A data", sda, m_da);
      chk(cur_req, "pin B data", sdb, m_db);
      chk("R9", "pin A enable", sda_oe, !cs_n);
      chk("R9", "pin B enable", sdb_oe, !cs_n && !m_single);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Rising start, then wait so the next call rises gap clocks later
  task automatic pulse(input int gap);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "pin A in reset", sda, 1'b0);
    chk("R1", "pin B in reset", sdb, 1'b0);
    rst_n = 1'b1;
    cur_req = "R11";
    tick(4);

    // R2 / R4: addressed conversion of pair 1
    cur_req = "R4";
    s_a0 = 12'h123; s_a1 = 12'h7FF; s_b0 = 12'h456; s_b1 = 12'h800;
    addr = 1'b1;
    pulse(20);
    addr = 1'b0;
    pulse(20);

    // R8: back-to-back frames every 16 clocks, end and start in one cycle
    cur_req = "R8";
    addr = 1'b1;
    pulse(16);
    addr = 1'b0;
    pulse(16);
    pulse(20);

    // R10: samples change mid-frame
    cur_req = "R10";
    s_a0 = 12'hA5A; s_b0 = 12'h5A5;
    pulse(6);
    s_a0 = 12'hFFF; s_b0 = 12'h000;
    tick(16);

    // R7: start inside a two-pin frame is ignored
    cur_req = "R7";
    pulse(7);
    pulse(16);

    // R3: boundary codes
    cur_req = "R3";
    s_a0 = 12'h000; s_b0 = 12'hFFF; s_a1 = 12'h800; s_b1 = 12'h001;
    pulse(18);
    addr = 1'b1;
    pulse(18);

    // R5: automatic alternation, address ignored
    cur_req = "R5";
    mode = 2'b01;
    addr = 1'b1;
    pulse(18);
    addr = 1'b0;
    pulse(18);
    pulse(18);
    mode = 2'b00;
    pulse(18);
    mode = 2'b01;
    pulse(18);

    // R6 / R7: single-pin mode, starts every 16 clocks
    cur_req = "R6";
    mode = 2'b10;
    s_a0 = 12'h3C7; s_b0 = 12'hC38;
    pulse(16);
    pulse(16);
    pulse(16);
    pulse(16);
    tick(20);
    mode = 2'b11;
    pulse(16);
    pulse(16);
    pulse(36);

    // R9: chip select high during frames
    cur_req = "R9";
    mode = 2'b00;
    pulse(4);
    cs_n = 1'b1;
    tick(14);
    mode = 2'b10;
    pulse(10);
    cs_n = 1'b0;
    tick(30);
    mode = 2'b00;
    cur_req = "R11";
    tick(10);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule